// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM interface. It owns the command pins from reset until the memory is ready for use. It keeps the bus quiet with clock-enable low through a long settling interval, then raises clock-enable. After a short lead it closes every bank with one precharge-all command. It then runs a configurable burst of auto-refresh commands and finally programs the mode register with a caller-supplied word. Each command is placed an exact, parameterised number of clock cycles after the one before it.

Once the last mode-register wait has run out, a sticky `done` flag rises and the command bus is left idle, so the main controller can take it over. The mode word is captured while reset is held and is not read again. Every interval is given in clock cycles, so the integrator converts the memory's nanosecond and millisecond limits for the clock frequency in use.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst` is high, and for exactly STAB_CYC cycles after it falls, `cke` is 0 and the bus carries NOP: `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1. `done` is 0 and `addr`/`ba` are 0.
- R2: `cke` then rises. It stays high until the next reset. Exactly CKE_LEAD NOP cycles with `cke` high come before the first command. No command ever appears in a cycle that follows one with `cke` low.
- R3: Exactly one precharge-all is issued, encoded `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, with `addr[10]`=1, every other `addr` bit 0 and `ba`=0.
- R4: The first auto-refresh (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, `cke`=1, `addr`=0, `ba`=0) appears exactly T_RP_CYC cycles after the precharge-all.
- R5: Exactly N_REF auto-refresh commands are issued, each exactly T_RC_CYC cycles after the previous one.
- R6: The mode-register write (`cs_n`, `ras_n`, `cas_n`, `we_n` all 0) appears exactly T_RC_CYC cycles after the last refresh. It carries the captured mode word on `addr[6:0]`, with 0 on `addr[11:7]` and on `ba`.
- R7: The mode word is the value on `mode_word` during the last reset cycle. Changes to `mode_word` after reset falls have no effect on the programmed value.
- R8: `done` rises exactly T_MRD_CYC cycles after the mode-register write and stays high until reset. Every cycle that is not one of the commands above, including every cycle while `done` is high, is a NOP.
- R9: Asserting `rst` at any point restarts the whole sequence. The registered outputs return to the R1 state on the clock edge that samples `rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_word | input | 7 | Mode register value (burst length, burst type, CAS latency), captured during reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select lines |
| addr | output | 12 | Address lines; carry the precharge-all flag and the mode word |
| done | output | 1 | Initialization complete; sticky until reset |

## Verification
A wrong phase or counter value inside the sequencer shows up at the pins as a command out of place. The error appears in the same cycle the command would have been due: a refresh count that is off by one moves the mode-register write by a full T_RC_CYC window, and a mis-loaded gap counter shifts the next command by the error amount. The bench time-stamps every command seen on the pins and compares each spacing and encoding against the parameters. A stray mode word, a late `cke` rise or a command after `done` therefore fails a check at the first sample where it appears. Reset is also asserted in the middle of the refresh burst, to show that the bus falls back to the quiet state on the next edge.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    localparam int ADDR_W = 12;
    localparam int BA_W   = 2;
    localparam int MODE_W = 7;
    localparam int AP_BIT = 10;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } boot_cmd_e;

    typedef enum logic [3:0] {
        PH_STAB    = 4'd0,
        PH_LEAD    = 4'd1,
        PH_PRE     = 4'd2,
        PH_GAP_RP  = 4'd3,
        PH_REF     = 4'd4,
        PH_GAP_RC  = 4'd5,
        PH_MRS     = 4'd6,
        PH_GAP_MRD = 4'd7,
        PH_DONE    = 4'd8
    } boot_phase_e;

    typedef struct packed {
        logic              cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } cmd_bus_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_bus_t encode_cmd(input boot_cmd_e c, input logic [MODE_W-1:0] m);
        cmd_bus_t b;
        b.cs_n  = 1'b0;
        b.ras_n = 1'b1;
        b.cas_n = 1'b1;
        b.we_n  = 1'b1;
        b.ba    = '0;
        b.addr  = '0;
        case (c)
            CMD_PRE: begin
                b.ras_n        = 1'b0;
                b.we_n         = 1'b0;
                b.addr[AP_BIT] = 1'b1;
            end
            CMD_REF: begin
                b.ras_n = 1'b0;
                b.cas_n = 1'b0;
            end
            CMD_MRS: begin
                b.ras_n = 1'b0;
                b.cas_n = 1'b0;
                b.we_n  = 1'b0;
                b.addr  = {{(ADDR_W-MODE_W){1'b0}}, m};
            end
            default: ;
        endcase
        return b;
    endfunction

    function automatic logic bus_is_nop(input cmd_bus_t b);
        return !b.cs_n && b.ras_n && b.cas_n && b.we_n;
    endfunction

endpackage

// File: rtl/sdram_boot_timer.sv
module sdram_boot_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero = (cnt_q == '0);

    // R5: an unloaded, non-zero count steps down by one each cycle
    p_timer_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R8: a drained counter stays drained until reloaded
    p_timer_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sdram_boot_fsm.sv
module sdram_boot_fsm
    import sdram_boot_pkg::*;
#(
    parameter int CKE_LEAD  = 1,
    parameter int T_RP_CYC  = 8,
    parameter int T_RC_CYC  = 23,
    parameter int N_REF     = 8,
    parameter int T_MRD_CYC = 2,
    parameter int CNT_W     = 8,
    parameter int REF_W     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             zero,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output boot_cmd_e        cmd,
    output logic             cke_req,
    output logic             done_req
);
    localparam logic [CNT_W-1:0] LEAD_LD = CNT_W'(CKE_LEAD - 1);
    localparam logic [CNT_W-1:0] RP_LD   = CNT_W'(T_RP_CYC - 2);
    localparam logic [CNT_W-1:0] RC_LD   = CNT_W'(T_RC_CYC - 2);
    localparam logic [CNT_W-1:0] MRD_LD  = CNT_W'(T_MRD_CYC - 2);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(N_REF);

    boot_phase_e      phase_q, phase_d;
    logic [REF_W-1:0] ref_q;
    logic             ref_inc;

    always_comb begin
        phase_d  = phase_q;
        load     = 1'b0;
        load_val = '0;
        cmd      = CMD_NOP;
        cke_req  = 1'b1;
        done_req = 1'b0;
        ref_inc  = 1'b0;
        case (phase_q)
            PH_STAB: begin
                cke_req = 1'b0;
                if (zero) begin
                    phase_d  = PH_LEAD;
                    load     = 1'b1;
                    load_val = LEAD_LD;
                end
            end
            PH_LEAD: begin
                if (zero) phase_d = PH_PRE;
            end
            PH_PRE: begin
                cmd      = CMD_PRE;
                load     = 1'b1;
                load_val = RP_LD;
                phase_d  = PH_GAP_RP;
            end
            PH_GAP_RP: begin
                if (zero) phase_d = PH_REF;
            end
            PH_REF: begin
                cmd      = CMD_REF;
                ref_inc  = 1'b1;
                load     = 1'b1;
                load_val = RC_LD;
                phase_d  = PH_GAP_RC;
            end
            PH_GAP_RC: begin
                if (zero) phase_d = (ref_q == REF_LAST) ? PH_MRS : PH_REF;
            end
            PH_MRS: begin
                cmd      = CMD_MRS;
                load     = 1'b1;
                load_val = MRD_LD;
                phase_d  = PH_GAP_MRD;
            end
            PH_GAP_MRD: begin
                if (zero) phase_d = PH_DONE;
            end
            PH_DONE: begin
                done_req = 1'b1;
            end
            default: phase_d = PH_STAB;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_STAB;
            ref_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (ref_inc) ref_q <= ref_q + REF_W'(1);
        end
    end

    // R5: a refresh is never issued once the full count is reached
    p_ref_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_REF) |-> (ref_q < REF_LAST));

    // R6: the mode write only follows the complete refresh burst
    p_mrs_after_refs_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_MRS) |-> (ref_q == REF_LAST));

    // R8: the finished phase is terminal
    p_done_terminal_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DONE) |=> (phase_q == PH_DONE));
endmodule

// File: rtl/sdram_boot_drive.sv
module sdram_boot_drive
    import sdram_boot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_word,
    input  boot_cmd_e         cmd,
    input  logic              cke_req,
    input  logic              done_req,
    output logic              cke_o,
    output cmd_bus_t          bus_o,
    output logic              done_o
);
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= mode_word;
            cke_o  <= 1'b0;
            bus_o  <= encode_cmd(CMD_NOP, '0);
            done_o <= 1'b0;
        end else begin
            cke_o  <= cke_req;
            bus_o  <= encode_cmd(cmd, mode_q);
            done_o <= done_req;
        end
    end

    // R2: clock enable never drops once raised
    p_cke_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cke_o |=> cke_o);

    // R2: a command needs clock enable high in the cycle before it
    p_cmd_needs_cke_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(cke_o) |-> bus_is_nop(bus_o));

    // R8: done is sticky and the bus is idle while it is high
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);
    p_quiet_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (bus_is_nop(bus_o) && cke_o));

    // R7: captured mode word is frozen outside reset
    p_mode_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    // R3: a precharge on the bus always closes all banks
    p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
        (!bus_o.cs_n && !bus_o.ras_n && bus_o.cas_n && !bus_o.we_n) |-> bus_o.addr[AP_BIT]);
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int STAB_CYC  = 50_000_000,
    parameter int CKE_LEAD  = 1,
    parameter int T_RP_CYC  = 8,
    parameter int T_RC_CYC  = 23,
    parameter int N_REF     = 8,
    parameter int T_MRD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_word,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam int MAX_WAIT = max2(max2(STAB_CYC, CKE_LEAD),
                                   max2(max2(T_RP_CYC, T_RC_CYC), T_MRD_CYC));
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int REF_W    = $clog2(N_REF + 1);

    logic             zero, load, cke_req, done_req;
    logic [CNT_W-1:0] load_val;
    boot_cmd_e        cmd;
    cmd_bus_t         bus;

    sdram_boot_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (STAB_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .zero     (zero)
    );

    sdram_boot_fsm #(
        .CKE_LEAD  (CKE_LEAD),
        .T_RP_CYC  (T_RP_CYC),
        .T_RC_CYC  (T_RC_CYC),
        .N_REF     (N_REF),
        .T_MRD_CYC (T_MRD_CYC),
        .CNT_W     (CNT_W),
        .REF_W     (REF_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .zero     (zero),
        .load     (load),
        .load_val (load_val),
        .cmd      (cmd),
        .cke_req  (cke_req),
        .done_req (done_req)
    );

    sdram_boot_drive u_drive (
        .clk       (clk),
        .rst       (rst),
        .mode_word (mode_word),
        .cmd       (cmd),
        .cke_req   (cke_req),
        .done_req  (done_req),
        .cke_o     (cke),
        .bus_o     (bus),
        .done_o    (done)
    );

    assign cs_n  = bus.cs_n;
    assign ras_n = bus.ras_n;
    assign cas_n = bus.cas_n;
    assign we_n  = bus.we_n;
    assign ba    = bus.ba;
    assign addr  = bus.addr;
endmodule

// File: tb/sdram_boot_seq_bench.sv
module sdram_boot_seq_bench;
    localparam int STAB  = 20;
    localparam int LEAD  = 2;
    localparam int TRP   = 3;
    localparam int TRC   = 5;
    localparam int NREF  = 8;
    localparam int TMRD  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  mode_word = 7'h00;
    logic        cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0]  ba;
    logic [11:0] addr;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    sdram_boot_seq #(
        .STAB_CYC (STAB), .CKE_LEAD (LEAD), .T_RP_CYC (TRP),
        .T_RC_CYC (TRC), .N_REF (NREF), .T_MRD_CYC (TMRD)
    ) u_sdram_boot_seq (
        .clk (clk), .rst (rst), .mode_word (mode_word),
        .cke (cke), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr), .done (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit pins_nop();
        return !cs_n && ras_n && cas_n && we_n;
    endfunction

    // R1 / R9: quiet bus state
    task automatic check_quiet(input string req);
        check(pins_nop() && !cke && !done && addr == 12'h000 && ba == 2'b00,
              req, "quiet bus state", {cke, done, cs_n, ras_n, cas_n, we_n}, 6'b000111);
    endtask

    // Full sequence: mode m_rst during reset, m_late afterwards (R7)
    task automatic run_full(input logic [6:0] m_rst, input logic [6:0] m_late);
        int cke_rise = 0, pre_at = 0, pre_cnt = 0, ref_cnt = 0, mrs_at = 0, done_at = 0;
        int bad_spacing = 0, stray = 0, cke_drop = 0, done_drop = 0, bad_ref_enc = 0, stab_bad = 0;
        int ref_at[16];
        logic [11:0] pre_addr = '0, mrs_addr = '0;
        logic [1:0]  pre_ba = '0, mrs_ba = '0;
        @(negedge clk);
        rst = 1'b1;
        mode_word = m_rst;
        repeat (3) @(negedge clk);
        check_quiet("R1");
        rst = 1'b0;
        mode_word = m_late;
        for (int n = 1; n <= 140; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (cke_rise == 0 && cke) cke_rise = n;
            if (cke_rise == 0 && !pins_nop()) stab_bad++;
            if (cke_rise != 0 && !cke) cke_drop++;
            if (done_at == 0 && done) done_at = n;
            if (done_at != 0 && !done) done_drop++;
            if (!cs_n && !ras_n && cas_n && !we_n) begin
                pre_cnt++; pre_at = n; pre_addr = addr; pre_ba = ba;
            end else if (!cs_n && !ras_n && !cas_n && we_n) begin
                if (ref_cnt < 16) ref_at[ref_cnt] = n;
                if (ref_cnt > 0 && n - ref_at[ref_cnt-1] != TRC) bad_spacing++;
                if (addr != 0 || ba != 0 || !cke) bad_ref_enc++;
                ref_cnt++;
            end else if (!cs_n && !ras_n && !cas_n && !we_n) begin
                mrs_at = n; mrs_addr = addr; mrs_ba = ba;
            end else if (!pins_nop() || (done_at != 0 && n > done_at && !pins_nop())) begin
                stray++;
            end
        end
        check(cke_rise == STAB + 1, "R1", "cycles with cke low after reset", cke_rise - 1, STAB);
        check(stab_bad == 0, "R1", "non-NOP while cke low", stab_bad, 0);
        check(pre_at - cke_rise == LEAD, "R2", "cke lead before precharge", pre_at - cke_rise, LEAD);
        check(cke_drop == 0, "R2", "cke dropped after rising", cke_drop, 0);
        check(pre_cnt == 1, "R3", "precharge-all count", pre_cnt, 1);
        check(pre_addr == 12'h400 && pre_ba == 2'b00, "R3", "precharge-all address", pre_addr, 12'h400);
        check(ref_cnt == NREF, "R5", "refresh count", ref_cnt, NREF);
        if (ref_cnt >= 1) begin
            check(ref_at[0] - pre_at == TRP, "R4", "precharge to first refresh", ref_at[0] - pre_at, TRP);
            check(bad_ref_enc == 0, "R4", "refresh encoding errors", bad_ref_enc, 0);
            check(bad_spacing == 0, "R5", "refresh spacing errors", bad_spacing, 0);
        end
        if (ref_cnt >= 1 && ref_cnt <= 16)
            check(mrs_at - ref_at[ref_cnt-1] == TRC, "R6", "last refresh to mode write",
                  mrs_at - ref_at[ref_cnt-1], TRC);
        check(mrs_addr == {5'b0, m_rst} && mrs_ba == 2'b00, "R6", "mode write address",
              mrs_addr, {5'b0, m_rst});
        check(mrs_addr[6:0] != m_late, "R7", "late mode_word leaked into mode write",
              mrs_addr[6:0], m_rst);
        check(done_at - mrs_at == TMRD, "R8", "mode write to done", done_at - mrs_at, TMRD);
        check(done_drop == 0, "R8", "done fell", done_drop, 0);
        check(stray == 0, "R8", "unexpected commands", stray, 0);
    endtask

    // R9: reset in the middle of the refresh burst
    task automatic run_mid_reset();
        @(negedge clk);
        rst = 1'b1;
        mode_word = 7'h32;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (STAB + LEAD + TRP + 2 * TRC + 1) @(negedge clk);
        check(cke == 1'b1, "R9", "cke high before mid reset", cke, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_quiet("R9");
        check(done == 1'b0, "R9", "done after mid reset", done, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        run_full(7'h23, 7'h5c);
        run_mid_reset();
        run_full(7'h32, 7'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule